// File: doc/BRIEF.md
# Accumulator ALU with Carry Flag

This block is the accumulator slice of a small 8-bit processor. It holds the accumulator and its carry/borrow flag, and it executes the group of immediate-operand instructions. An instruction sequencer gives it a 4-bit operation code and an operand byte taken from memory, then raises the execute strobe for one clock. On that edge the block writes the new accumulator value and flag. In the same cycle it tells the sequencer whether the program pointer must advance past the operand byte.

The operations are load, OR, AND, XOR, add, two subtractions and shift-left. The two subtractions run in opposite directions: operand minus accumulator, and accumulator minus operand. Both run through one ripple adder as an add of the two's complement, so the flag holds the adder's carry-out. For a subtraction a flag of 1 means that no borrow happened. Shift-left takes no operand, so it does not advance the pointer.

Top module: `acc_alu_slice`

## Requirements
- R1: When `rst` is high at a rising edge, the accumulator and flag are cleared to 0 whatever `exec_en` is, and `ptr_inc` is low while `rst` is high.
- R2: At an edge where `exec_en` is low, the accumulator and flag keep their values, and `ptr_inc` is low.
- R3: Code 4'h8 loads the operand into the accumulator, leaves the flag unchanged and raises `ptr_inc`.
- R4: Code 4'h9 writes operand OR accumulator, code 4'hA writes operand AND accumulator, and code 4'hB writes operand XOR accumulator. The flag is unchanged and `ptr_inc` is raised.
- R5: Code 4'hC writes the low 8 bits of operand plus accumulator, sets the flag to the carry out of bit 7 and raises `ptr_inc`.
- R6: Code 4'hD writes operand minus accumulator modulo 256. The flag becomes 1 when operand >= accumulator (no borrow) and 0 otherwise. `ptr_inc` is raised.
- R7: Code 4'hF writes accumulator minus operand modulo 256. The flag becomes 1 when accumulator >= operand (no borrow) and 0 otherwise. `ptr_inc` is raised.
- R8: Code 4'hE shifts the accumulator left by one with a 0 into bit 0, moves the old bit 7 into the flag and does not raise `ptr_inc`. The operand is ignored.
- R9: Codes 4'h0 to 4'h7 leave the accumulator and flag unchanged and do not raise `ptr_inc`.
- R10: `ptr_inc` is combinational. It is high in exactly the cycle where `exec_en` is high with a code of 4'h8 to 4'hD or 4'hF, and low at every other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| exec_en | input | 1 | Execute strobe, one cycle per instruction |
| op_code | input | 4 | Operation code (low nibble of the instruction) |
| mem_opnd | input | 8 | Operand byte read from memory |
| acc_q | output | 8 | Accumulator value |
| carry_q | output | 1 | Carry / no-borrow flag |
| ptr_inc | output | 1 | Request to advance the program pointer |

## Verification
The flag is hard to reach from the ports because only add, subtract and shift can set it, while every check needs a chosen accumulator value together with a chosen flag value. The bench brings the block to each starting state through its normal instructions. For a flag of 1 it loads 0x80 and shifts. For a flag of 0 it loads 0 and adds 0. It then loads the target accumulator value, which leaves the flag alone. This lets each code run with both flag values, so the bench can confirm that load, the logic operations and the unused codes preserve a set flag as well as a clear one. The subtractions are run at the equal-operand boundary and on both sides of it.

// File: rtl/acc_alu_pkg.sv
`timescale 1ns/1ps
package acc_alu_pkg;

  localparam int CODE_W = 4;

  typedef enum logic [CODE_W-1:0] {
    OPC_LOAD = 4'h8,
    OPC_OR   = 4'h9,
    OPC_AND  = 4'hA,
    OPC_XOR  = 4'hB,
    OPC_ADD  = 4'hC,
    OPC_RSUB = 4'hD,
    OPC_SHL  = 4'hE,
    OPC_SUB  = 4'hF
  } op_code_e;

  typedef enum logic [2:0] {
    CLS_NONE  = 3'd0,
    CLS_LOAD  = 3'd1,
    CLS_LOGIC = 3'd2,
    CLS_ARITH = 3'd3,
    CLS_SHIFT = 3'd4
  } op_class_e;

  typedef enum logic [1:0] {
    LG_OR  = 2'd0,
    LG_AND = 2'd1,
    LG_XOR = 2'd2
  } logic_sel_e;

  // AR_MMD: operand minus accumulator, AR_DMM: accumulator minus operand
  typedef enum logic [1:0] {
    AR_ADD = 2'd0,
    AR_MMD = 2'd1,
    AR_DMM = 2'd2
  } arith_sel_e;

  typedef struct packed {
    op_class_e  cls;
    logic_sel_e lsel;
    arith_sel_e asel;
    logic       wr_acc;
    logic       wr_flag;
    logic       bump;
  } dec_t;

endpackage

// File: rtl/acc_alu_decode.sv
`timescale 1ns/1ps
module acc_alu_decode
  import acc_alu_pkg::*;
(
  input  logic [CODE_W-1:0] op_code,
  output dec_t              dec
);

  always_comb begin
    dec         = '0;
    dec.cls     = CLS_NONE;
    dec.lsel    = LG_OR;
    dec.asel    = AR_ADD;
    case (op_code)
      OPC_LOAD: begin
        dec.cls    = CLS_LOAD;
        dec.wr_acc = 1'b1;
        dec.bump   = 1'b1;
      end
      OPC_OR, OPC_AND, OPC_XOR: begin
        dec.cls    = CLS_LOGIC;
        dec.wr_acc = 1'b1;
        dec.bump   = 1'b1;
        case (op_code)
          OPC_AND: dec.lsel = LG_AND;
          OPC_XOR: dec.lsel = LG_XOR;
          default: dec.lsel = LG_OR;
        endcase
      end
      OPC_ADD, OPC_RSUB, OPC_SUB: begin
        dec.cls     = CLS_ARITH;
        dec.wr_acc  = 1'b1;
        dec.wr_flag = 1'b1;
        dec.bump    = 1'b1;
        case (op_code)
          OPC_RSUB: dec.asel = AR_MMD;
          OPC_SUB:  dec.asel = AR_DMM;
          default:  dec.asel = AR_ADD;
        endcase
      end
      OPC_SHL: begin
        dec.cls     = CLS_SHIFT;
        dec.wr_acc  = 1'b1;
        dec.wr_flag = 1'b1;
        dec.bump    = 1'b0;
      end
      default: begin
        dec.cls = CLS_NONE;
      end
    endcase
  end

endmodule

// File: rtl/acc_alu_logic.sv
`timescale 1ns/1ps
module acc_alu_logic
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic_sel_e     sel,
  input  logic [W-1:0]   opnd,
  input  logic [W-1:0]   acc,
  output logic [W-1:0]   res
);

  function automatic logic bit_op(logic_sel_e s, logic a, logic b);
    case (s)
      LG_AND:  return a & b;
      LG_XOR:  return a ^ b;
      default: return a | b;
    endcase
  endfunction

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign res[i] = bit_op(sel, opnd[i], acc[i]);
  end

endmodule

// File: rtl/acc_alu_addsub.sv
`timescale 1ns/1ps
module acc_alu_addsub
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  arith_sel_e     sel,
  input  logic [W-1:0]   opnd,
  input  logic [W-1:0]   acc,
  output logic [W-1:0]   sum,
  output logic           cout
);

  logic [W-1:0] a_in;
  logic [W-1:0] b_in;
  logic         c_in;
  logic [W:0]   chain;

  // subtraction = add of the two's complement; carry out is then "no borrow"
  always_comb begin
    case (sel)
      AR_MMD: begin
        a_in = opnd;
        b_in = ~acc;
        c_in = 1'b1;
      end
      AR_DMM: begin
        a_in = acc;
        b_in = ~opnd;
        c_in = 1'b1;
      end
      default: begin
        a_in = opnd;
        b_in = acc;
        c_in = 1'b0;
      end
    endcase
  end

  function automatic logic [1:0] full_add(logic a, logic b, logic c);
    return {(a & b) | (a & c) | (b & c), a ^ b ^ c};
  endfunction

  assign chain[0] = c_in;

  for (genvar i = 0; i < W; i++) begin : g_fa
    assign {chain[i+1], sum[i]} = full_add(a_in[i], b_in[i], chain[i]);
  end

  assign cout = chain[W];

endmodule

// File: rtl/acc_alu_shift.sv
`timescale 1ns/1ps
module acc_alu_shift #(
  parameter int W = 8
) (
  input  logic [W-1:0] acc,
  output logic [W-1:0] res,
  output logic         msb_out
);

  assign res     = {acc[W-2:0], 1'b0};
  assign msb_out = acc[W-1];

endmodule

// File: rtl/acc_alu_slice.sv
`timescale 1ns/1ps
module acc_alu_slice
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              exec_en,
  input  logic [CODE_W-1:0] op_code,
  input  logic [DATA_W-1:0] mem_opnd,
  output logic [DATA_W-1:0] acc_q,
  output logic              carry_q,
  output logic              ptr_inc
);

  dec_t              dec;
  logic [DATA_W-1:0] logic_res;
  logic [DATA_W-1:0] arith_res;
  logic              arith_cout;
  logic [DATA_W-1:0] shift_res;
  logic              shift_msb;
  logic [DATA_W-1:0] next_acc;
  logic              next_flag;
  logic              acc_load;
  logic              flag_load;

  acc_alu_decode u_dec (
    .op_code (op_code),
    .dec     (dec)
  );

  acc_alu_logic #(.W(DATA_W)) u_logic (
    .sel  (dec.lsel),
    .opnd (mem_opnd),
    .acc  (acc_q),
    .res  (logic_res)
  );

  acc_alu_addsub #(.W(DATA_W)) u_arith (
    .sel  (dec.asel),
    .opnd (mem_opnd),
    .acc  (acc_q),
    .sum  (arith_res),
    .cout (arith_cout)
  );

  acc_alu_shift #(.W(DATA_W)) u_shift (
    .acc     (acc_q),
    .res     (shift_res),
    .msb_out (shift_msb)
  );

  always_comb begin
    next_acc  = acc_q;
    next_flag = carry_q;
    case (dec.cls)
      CLS_LOAD:  next_acc = mem_opnd;
      CLS_LOGIC: next_acc = logic_res;
      CLS_ARITH: begin
        next_acc  = arith_res;
        next_flag = arith_cout;
      end
      CLS_SHIFT: begin
        next_acc  = shift_res;
        next_flag = shift_msb;
      end
      default: ;
    endcase
  end

  assign acc_load  = exec_en & dec.wr_acc;
  assign flag_load = exec_en & dec.wr_flag;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      carry_q <= 1'b0;
    end else begin
      if (acc_load)  acc_q   <= next_acc;
      if (flag_load) carry_q <= next_flag;
    end
  end

  assign ptr_inc = exec_en & dec.bump & ~rst;

endmodule

// File: rtl/acc_alu_checks.sv
`timescale 1ns/1ps
module acc_alu_checks #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         exec_en,
  input logic [3:0]   op_code,
  input logic [W-1:0] mem_opnd,
  input logic [W-1:0] acc_q,
  input logic         carry_q,
  input logic         ptr_inc
);

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (acc_q == '0) && !carry_q);

  a_r1_no_bump_in_reset: assert property (@(posedge clk)
    rst |-> !ptr_inc);

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !exec_en |=> $stable(acc_q) && $stable(carry_q));

  a_r3_load: assert property (@(posedge clk) disable iff (rst)
    (exec_en && op_code == 4'h8) |=> (acc_q == $past(mem_opnd)) && $stable(carry_q));

  a_r6_rsub_flag: assert property (@(posedge clk) disable iff (rst)
    (exec_en && op_code == 4'hD) |=> carry_q == ($past(mem_opnd) >= $past(acc_q)));

  a_r7_sub_flag: assert property (@(posedge clk) disable iff (rst)
    (exec_en && op_code == 4'hF) |=> carry_q == ($past(acc_q) >= $past(mem_opnd)));

  a_r8_shift: assert property (@(posedge clk) disable iff (rst)
    (exec_en && op_code == 4'hE) |=>
      (acc_q == ($past(acc_q) << 1)) && (carry_q == $past(acc_q[W-1])));

  a_r9_unused_noop: assert property (@(posedge clk) disable iff (rst)
    (exec_en && !op_code[3]) |=> $stable(acc_q) && $stable(carry_q));

  a_r10_bump_only_on_exec: assert property (@(posedge clk) disable iff (rst)
    ptr_inc |-> exec_en && op_code[3] && (op_code != 4'hE));

  a_r10_bump_when_due: assert property (@(posedge clk) disable iff (rst)
    (exec_en && op_code[3] && op_code != 4'hE) |-> ptr_inc);

endmodule

bind acc_alu_slice acc_alu_checks #(.W(DATA_W)) u_checks (.*);

// File: tb/acc_alu_slice_test.sv
`timescale 1ns/1ps
module acc_alu_slice_test;

  logic       clk = 1'b0;
  logic       rst;
  logic       exec_en;
  logic [3:0] op_code;
  logic [7:0] mem_opnd;
  logic [7:0] acc_q;
  logic       carry_q;
  logic       ptr_inc;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  acc_alu_slice uut (
    .clk      (clk),
    .rst      (rst),
    .exec_en  (exec_en),
    .op_code  (op_code),
    .mem_opnd (mem_opnd),
    .acc_q    (acc_q),
    .carry_q  (carry_q),
    .ptr_inc  (ptr_inc)
  );

  // {code, operand, start acc, start flag}
  localparam int NV = 18;
  localparam logic [20:0] VEC [NV] = '{
    {4'h8, 8'h3C, 8'hA5, 1'b1},
    {4'h9, 8'h0F, 8'h50, 1'b0},
    {4'hA, 8'hF0, 8'h3C, 1'b1},
    {4'hB, 8'hFF, 8'h5A, 1'b0},
    {4'hC, 8'h7F, 8'h01, 1'b0},
    {4'hC, 8'hFF, 8'h01, 1'b0},
    {4'hC, 8'h80, 8'h80, 1'b1},
    {4'hD, 8'h50, 8'h20, 1'b0},
    {4'hD, 8'h20, 8'h50, 1'b1},
    {4'hD, 8'h44, 8'h44, 1'b0},
    {4'hF, 8'h50, 8'h20, 1'b1},
    {4'hF, 8'h20, 8'h50, 1'b0},
    {4'hF, 8'h00, 8'h00, 1'b0},
    {4'hE, 8'h12, 8'h81, 1'b0},
    {4'hE, 8'h00, 8'h40, 1'b1},
    {4'h3, 8'hAA, 8'h77, 1'b1},
    {4'h0, 8'hFF, 8'h33, 1'b0},
    {4'h7, 8'h11, 8'hFF, 1'b1}
  };

  function automatic string req_of(logic [3:0] c);
    case (c)
      4'h8: return "R3";
      4'h9, 4'hA, 4'hB: return "R4";
      4'hC: return "R5";
      4'hD: return "R6";
      4'hF: return "R7";
      4'hE: return "R8";
      default: return "R9";
    endcase
  endfunction

  // independent model: integer arithmetic, flag from sign/range
  task automatic model(input logic [3:0] c, input int m, input int d, input bit f,
                       output int nd, output bit nf, output bit bump);
    int s;
    nd = d; nf = f; bump = 1'b0;
    case (c)
      4'h8: begin nd = m; bump = 1; end
      4'h9: begin nd = m | d; bump = 1; end
      4'hA: begin nd = m & d; bump = 1; end
      4'hB: begin nd = m ^ d; bump = 1; end
      4'hC: begin s = m + d; nd = s % 256; nf = (s > 255); bump = 1; end
      4'hD: begin s = m - d; nd = (s + 256) % 256; nf = (s >= 0); bump = 1; end
      4'hF: begin s = d - m; nd = (s + 256) % 256; nf = (s >= 0); bump = 1; end
      4'hE: begin nd = (d * 2) % 256; nf = (d >= 128); end
      default: ;
    endcase
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one execute cycle; bump sampled while strobe is high
  task automatic run_op(input logic [3:0] c, input logic [7:0] m, output bit bump_seen);
    @(negedge clk);
    op_code  = c;
    mem_opnd = m;
    exec_en  = 1'b1;
    #1 bump_seen = ptr_inc;
    @(negedge clk);
    exec_en = 1'b0;
  endtask

  task automatic preset(input logic [7:0] d, input bit f);
    bit b;
    if (f) begin
      run_op(4'h8, 8'h80, b);
      run_op(4'hE, 8'h00, b);
    end else begin
      run_op(4'h8, 8'h00, b);
      run_op(4'hC, 8'h00, b);
    end
    run_op(4'h8, d, b);
  endtask

  initial begin
    #400000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    bit b;
    int nd;
    bit nf, nb;
    rst = 1'b1; exec_en = 1'b0; op_code = 4'h0; mem_opnd = 8'h00;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1", "acc after reset", acc_q, 0);
    check("R1", "flag after reset", carry_q, 0);
    exec_en = 1'b1; op_code = 4'h8; mem_opnd = 8'h5A;
    #1 check("R1", "bump in reset", ptr_inc, 0);
    @(negedge clk);
    check("R1", "reset beats load", acc_q, 0);
    exec_en = 1'b0;
    rst = 1'b0;

    // vector table walk
    for (int i = 0; i < NV; i++) begin
      logic [3:0] c;
      logic [7:0] m, d;
      bit f;
      {c, m, d, f} = VEC[i];
      preset(d, f);
      model(c, int'(m), int'(d), f, nd, nf, nb);
      run_op(c, m, b);
      check(req_of(c), "acc", acc_q, nd);
      check(req_of(c), "flag", carry_q, nf);
      check("R10", "pointer bump", b, nb);
    end

    // R2: strobe low, add code presented, nothing changes
    preset(8'hC3, 1'b1);
    @(negedge clk);
    op_code = 4'hC; mem_opnd = 8'hFF; exec_en = 1'b0;
    #1 check("R2", "bump while idle", ptr_inc, 0);
    repeat (2) @(negedge clk);
    check("R2", "acc held", acc_q, 8'hC3);
    check("R2", "flag held", carry_q, 1);

    // R8: operand ignored by shift, flag cleared from msb 0
    preset(8'h7F, 1'b1);
    run_op(4'hE, 8'hFF, b);
    check("R8", "shift acc", acc_q, 8'hFE);
    check("R8", "shift flag", carry_q, 0);
    check("R8", "shift no bump", b, 0);

    // R1: reset mid-run clears a nonzero state
    preset(8'h9E, 1'b1);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1", "acc after late reset", acc_q, 0);
    check("R1", "flag after late reset", carry_q, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule